// File: doc/BRIEF.md
# Variable-Length Immediate Decoder

This block rebuilds a 32-bit signed constant from the bytes that follow an opcode in a compact variable-length instruction stream. Each byte carries seven payload bits and a flag in bit 7 that tells whether another byte follows. Groups arrive most significant first. The decoder shifts the partial value left and appends each new group. When the closing byte arrives, it sign-extends the result from the highest bit collected. It then reports the value, a one-cycle completion pulse and the number of bytes consumed, so that fetch logic can step past the immediate.

A caller raises `start_i` when an immediate is about to begin. After that it presents one byte per cycle, qualified by `byte_valid_i`, and it may insert idle cycles between bytes. The longest legal encoding is five bytes. In the fifth byte only the low nibble is payload, which brings the total to exactly 32 bits. If a fifth byte still claims that more bytes follow, the decoder stops at that byte and flags a length error.

Top module: `vlid_decoder`

## Requirements
- R1: While `rst_n` is low and after it is released, `done_o` is 0, `imm_o` is 0, `nbytes_o` is 0 and `len_err_o` is 0, and the decoder is idle.
- R2: Bit 7 of an accepted byte set to 1 means another byte follows; set to 0 it ends the immediate. `done_o` is high for exactly the one cycle after the clock edge that accepts the ending byte.
- R3: Groups are taken most significant first: for each of the first four bytes, the value so far is shifted left by 7 and bits 6:0 of the byte fill the low end.
- R4: For an immediate of n bytes with n from 1 to 4, `imm_o` equals the 7n collected bits sign-extended to 32 bits from bit 7n-1. So a lone 0x7F gives 0xFFFFFFFF, and the pair 0x80, 0x7F gives 0x0000007F.
- R5: A fifth byte shifts the value left by 4 and inserts its bits 3:0. Its bits 6:4 are ignored, and the 32-bit result is not extended.
- R6: `nbytes_o` reports the byte count (1 to 5) of the immediate just finished. `imm_o`, `nbytes_o` and `len_err_o` change only in a cycle where `done_o` is high, and otherwise hold.
- R7: If the fifth byte has bit 7 set, decoding ends at that byte as in R5 and `len_err_o` is 1 with `nbytes_o` = 5. Any completion that ends on a byte with bit 7 clear gives `len_err_o` = 0.
- R8: Cycles with `byte_valid_i` low have no effect on the value or the count being built.
- R9: `start_i` discards any partial immediate. A byte that is valid in the same cycle as `start_i` is taken as the first byte of the new immediate.
- R10: Valid bytes presented while idle (after reset or after a completion, with no `start_i` since) are ignored: no `done_o` pulse follows and the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new immediate, discarding any partial one |
| byte_valid_i | input | 1 | `byte_i` carries an immediate byte this cycle |
| byte_i | input | 8 | Immediate byte: bit 7 continuation flag, bits 6:0 payload |
| imm_o | output | 32 | Sign-extended immediate of the last completion |
| done_o | output | 1 | One-cycle pulse: a new immediate is on the outputs |
| nbytes_o | output | 3 | Bytes consumed by the last immediate (1 to 5) |
| len_err_o | output | 1 | Last immediate ended on a fifth byte that still had bit 7 set |

## Verification
The bench targets sign extension at every length where the top collected bit is set. A design that extended from a fixed bit, or did not extend at all, would return large positive values where small negative ones belong. The fifth byte is driven with its bits 6:4 set. A decoder that shifted by seven there would lose the top three bits of the 28 collected, and one that kept bits 6:4 would corrupt the low end. The bench also places `start_i` in the middle of an immediate and alongside a valid byte, inserts gaps between bytes, and sends bytes while the decoder is idle. Stale groups, a dropped first byte, counting of idle cycles, or spurious pulses would each show up as a miscompare of value, count or pulse timing.

// File: rtl/vlid_pkg.sv
package vlid_pkg;

    // Default geometry of the encoding.
    localparam int unsigned IMM_W_DEF    = 32;  // result width
    localparam int unsigned GRP_W_DEF    = 7;   // payload bits per byte
    localparam int unsigned MAX_GRPS_DEF = 5;   // longest legal encoding

    // Width of a counter that must hold 0..max_grps.
    function automatic int unsigned cnt_width(input int unsigned max_grps);
        return $clog2(max_grps + 1);
    endfunction

    // Payload bits carried by the final, short byte.
    function automatic int unsigned tail_width(input int unsigned imm_w,
                                               input int unsigned grp_w,
                                               input int unsigned max_grps);
        return imm_w - grp_w * (max_grps - 1);
    endfunction

endpackage

// File: rtl/vlid_group_merge.sv
// Appends one payload group to the partial value, shifting it left by the
// group width; the final slot carries a shorter group.
module vlid_group_merge #(
    parameter int unsigned IMM_W  = 32,
    parameter int unsigned GRP_W  = 7,
    parameter int unsigned TAIL_W = 4
) (
    input  logic [IMM_W-1:0] acc_i,
    input  logic [7:0]       byte_i,
    input  logic             tail_slot_i,
    output logic [IMM_W-1:0] acc_o
);
    logic [IMM_W-1:0] wide_merge;
    logic [IMM_W-1:0] tail_merge;

    assign wide_merge = {acc_i[IMM_W-GRP_W-1:0], byte_i[GRP_W-1:0]};
    assign tail_merge = {acc_i[IMM_W-TAIL_W-1:0], byte_i[TAIL_W-1:0]};

    always_comb begin
        if (tail_slot_i) begin
            acc_o = tail_merge;
        end else begin
            acc_o = wide_merge;
        end
    end
endmodule

// File: rtl/vlid_term_detect.sv
// Decides whether the byte just taken ends the immediate and whether it
// ended by running out of slots.
module vlid_term_detect #(
    parameter int unsigned MAX_GRPS = 5,
    parameter int unsigned CNT_W    = 3
) (
    input  logic [CNT_W-1:0] prior_cnt_i,
    input  logic             cont_i,
    output logic [CNT_W-1:0] new_cnt_o,
    output logic             tail_slot_o,
    output logic             last_o,
    output logic             overrun_o
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(MAX_GRPS);
    localparam logic [CNT_W-1:0] TAIL_IDX = CNT_W'(MAX_GRPS - 1);

    always_comb begin
        new_cnt_o   = prior_cnt_i + CNT_W'(1);
        tail_slot_o = (prior_cnt_i == TAIL_IDX);
        overrun_o   = tail_slot_o && cont_i;
        last_o      = !cont_i || (new_cnt_o == FULL_CNT);
    end
endmodule

// File: rtl/vlid_sign_extend.sv
// Sign-extends the collected bits from the top bit of the last group;
// one candidate per length, selected by the byte count.
module vlid_sign_extend #(
    parameter int unsigned IMM_W    = 32,
    parameter int unsigned GRP_W    = 7,
    parameter int unsigned MAX_GRPS = 5,
    parameter int unsigned CNT_W    = 3
) (
    input  logic [IMM_W-1:0] raw_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [IMM_W-1:0] ext_o
);
    logic [IMM_W-1:0] cand [MAX_GRPS+1];

    assign cand[0]        = raw_i;
    assign cand[MAX_GRPS] = raw_i;

    for (genvar g = 1; g < MAX_GRPS; g++) begin : g_len
        localparam int unsigned KEEP = g * GRP_W;
        assign cand[g] = {{(IMM_W-KEEP){raw_i[KEEP-1]}}, raw_i[KEEP-1:0]};
    end

    always_comb begin
        ext_o = raw_i;
        for (int i = 0; i <= MAX_GRPS; i++) begin
            if (cnt_i == CNT_W'(i)) begin
                ext_o = cand[i];
            end
        end
    end
endmodule

// File: rtl/vlid_decoder.sv
module vlid_decoder #(
    parameter int unsigned IMM_W    = vlid_pkg::IMM_W_DEF,
    parameter int unsigned GRP_W    = vlid_pkg::GRP_W_DEF,
    parameter int unsigned MAX_GRPS = vlid_pkg::MAX_GRPS_DEF,
    parameter int unsigned CNT_W    = vlid_pkg::cnt_width(MAX_GRPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             byte_valid_i,
    input  logic [7:0]       byte_i,
    output logic [IMM_W-1:0] imm_o,
    output logic             done_o,
    output logic [CNT_W-1:0] nbytes_o,
    output logic             len_err_o
);
    localparam int unsigned TAIL_W = vlid_pkg::tail_width(IMM_W, GRP_W, MAX_GRPS);

    typedef struct packed {
        logic             busy;
        logic [IMM_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic [IMM_W-1:0] res;
        logic [CNT_W-1:0] res_cnt;
        logic             res_err;
    } state_t;

    state_t st_d, st_q;

    logic             take;
    logic [IMM_W-1:0] base_acc;
    logic [CNT_W-1:0] base_cnt;
    logic [IMM_W-1:0] merged;
    logic [CNT_W-1:0] new_cnt;
    logic             tail_slot;
    logic             is_last;
    logic             overrun;
    logic [IMM_W-1:0] extended;

    // A start wipes the partial value before this cycle's byte is merged.
    assign take     = byte_valid_i && (start_i || st_q.busy);
    assign base_acc = start_i ? '0 : st_q.acc;
    assign base_cnt = start_i ? '0 : st_q.cnt;

    vlid_term_detect #(
        .MAX_GRPS (MAX_GRPS),
        .CNT_W    (CNT_W)
    ) u_term (
        .prior_cnt_i (base_cnt),
        .cont_i      (byte_i[7]),
        .new_cnt_o   (new_cnt),
        .tail_slot_o (tail_slot),
        .last_o      (is_last),
        .overrun_o   (overrun)
    );

    vlid_group_merge #(
        .IMM_W  (IMM_W),
        .GRP_W  (GRP_W),
        .TAIL_W (TAIL_W)
    ) u_merge (
        .acc_i       (base_acc),
        .byte_i      (byte_i),
        .tail_slot_i (tail_slot),
        .acc_o       (merged)
    );

    vlid_sign_extend #(
        .IMM_W    (IMM_W),
        .GRP_W    (GRP_W),
        .MAX_GRPS (MAX_GRPS),
        .CNT_W    (CNT_W)
    ) u_sext (
        .raw_i (merged),
        .cnt_i (new_cnt),
        .ext_o (extended)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i) begin
            st_d.busy = 1'b1;
            st_d.acc  = '0;
            st_d.cnt  = '0;
        end
        if (take) begin
            if (is_last) begin
                st_d.busy    = 1'b0;
                st_d.acc     = '0;
                st_d.cnt     = '0;
                st_d.done    = 1'b1;
                st_d.res     = extended;
                st_d.res_cnt = new_cnt;
                st_d.res_err = overrun;
            end else begin
                st_d.busy = 1'b1;
                st_d.acc  = merged;
                st_d.cnt  = new_cnt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign imm_o     = st_q.res;
    assign done_o    = st_q.done;
    assign nbytes_o  = st_q.res_cnt;
    assign len_err_o = st_q.res_err;

endmodule

// File: rtl/vlid_checker.sv
module vlid_checker #(
    parameter int unsigned IMM_W    = 32,
    parameter int unsigned GRP_W    = 7,
    parameter int unsigned MAX_GRPS = 5,
    parameter int unsigned CNT_W    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_valid_i,
    input logic [IMM_W-1:0] imm_o,
    input logic             done_o,
    input logic [CNT_W-1:0] nbytes_o,
    input logic             len_err_o
);
    function automatic logic top_bits_ok(input logic [IMM_W-1:0] v,
                                         input logic [CNT_W-1:0] n);
        logic ok;
        ok = 1'b1;
        for (int k = 1; k < MAX_GRPS; k++) begin
            if (n == CNT_W'(k)) begin
                for (int b = k * GRP_W; b < IMM_W; b++) begin
                    if (v[b] != v[k*GRP_W-1]) ok = 1'b0;
                end
            end
        end
        return ok;
    endfunction

    // R2: a completion is always caused by a byte accepted one edge earlier.
    p_done_after_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(byte_valid_i));

    // R4: bits above the collected ones replicate the top collected bit.
    p_sext_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && nbytes_o < CNT_W'(MAX_GRPS)) |-> top_bits_ok(imm_o, nbytes_o));

    // R6: the reported count is always a legal length.
    p_count_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (nbytes_o >= CNT_W'(1) && nbytes_o <= CNT_W'(MAX_GRPS)));

    // R6: result outputs hold between completions.
    p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(imm_o) && $stable(nbytes_o) && $stable(len_err_o)));

    // R7: a length error only comes with a full-length count.
    p_err_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        len_err_o |-> (nbytes_o == CNT_W'(MAX_GRPS)));
endmodule

bind vlid_decoder vlid_checker #(
    .IMM_W    (IMM_W),
    .GRP_W    (GRP_W),
    .MAX_GRPS (MAX_GRPS),
    .CNT_W    (CNT_W)
) u_vlid_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_valid_i (byte_valid_i),
    .imm_o        (imm_o),
    .done_o       (done_o),
    .nbytes_o     (nbytes_o),
    .len_err_o    (len_err_o)
);

// File: tb/test_vlid_decoder.sv
`timescale 1ns/1ps
module test_vlid_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        byte_valid_i = 1'b0;
    logic [7:0]  byte_i = 8'h00;
    logic [31:0] imm_o;
    logic        done_o;
    logic [2:0]  nbytes_o;
    logic        len_err_o;

    vlid_decoder i_vlid_decoder (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .byte_valid_i (byte_valid_i),
        .byte_i       (byte_i),
        .imm_o        (imm_o),
        .done_o       (done_o),
        .nbytes_o     (nbytes_o),
        .len_err_o    (len_err_o)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit ended  = 0;

    // Behavioural reference state.
    bit          m_busy = 0;
    logic [7:0]  m_q[$];
    logic        e_done = 0;
    logic [31:0] e_val  = 0;
    int          e_cnt  = 0;
    logic        e_err  = 0;

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: run did not end, cycles=%0d expected<150000", cycles);
            finish_run();
        end
    end

    function automatic logic [31:0] ref_value(input logic [7:0] q[$]);
        logic [31:0] v = 0;
        int nb = 0;
        foreach (q[i]) begin
            if (i == 4) begin v = (v << 4) | 32'(q[i] & 8'h0F); nb += 4; end
            else        begin v = (v << 7) | 32'(q[i] & 8'h7F); nb += 7; end
        end
        if (nb < 32 && v[nb-1]) v = v | ~((32'd1 << nb) - 32'd1);
        return v;
    endfunction

    task automatic model(input bit s, input bit v, input logic [7:0] b);
        e_done = 0;
        if (s) begin m_q.delete(); m_busy = 1; end
        if (v && (s || m_busy)) begin
            m_q.push_back(b);
            if (!b[7] || m_q.size() == 5) begin
                e_done = 1;
                e_val  = ref_value(m_q);
                e_cnt  = m_q.size();
                e_err  = b[7];
                m_busy = 0;
                m_q.delete();
            end
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (done_o !== e_done || imm_o !== e_val || int'(nbytes_o) != e_cnt ||
            len_err_o !== e_err) begin
            fails++;
            $display("FAIL %s: got done=%0b val=%08h cnt=%0d err=%0b exp done=%0b val=%08h cnt=%0d err=%0b",
                     tag, done_o, imm_o, nbytes_o, len_err_o, e_done, e_val, e_cnt, e_err);
        end
    endtask

    task automatic step(input bit s, input bit v, input logic [7:0] b, input string tag);
        start_i = s; byte_valid_i = v; byte_i = b;
        model(s, v, b);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    // Send one immediate: start with the first byte, optional gap cycles.
    task automatic send(input logic [7:0] bs[$], input int gap, input string tag);
        foreach (bs[i]) begin
            step(i == 0, 1'b1, bs[i], tag);
            for (int g = 0; g < gap; g++) step(1'b0, 1'b0, 8'hFF, tag);
        end
        step(1'b0, 1'b0, 8'h00, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset");

        // R10: bytes while idle after reset are ignored.
        step(1'b0, 1'b1, 8'h05, "R10 idle byte");
        step(1'b0, 1'b0, 8'h00, "R10 idle byte");

        send('{8'h05}, 0, "R2 R3 one byte");
        send('{8'h7F}, 0, "R4 one byte negative");
        send('{8'h40}, 0, "R4 one byte top bit");
        send('{8'h80, 8'h7F}, 0, "R4 leading zero group");
        send('{8'h81, 8'h00}, 0, "R3 two bytes");
        send('{8'hC0, 8'h80, 8'h01}, 0, "R4 three bytes negative");
        send('{8'h81, 8'h82, 8'h83, 8'h04}, 1, "R3 R8 four bytes gaps");
        send('{8'hFF, 8'hFF, 8'hFF, 8'h7F}, 0, "R4 four bytes all ones");
        send('{8'h8F, 8'hFF, 8'hFF, 8'hFF, 8'h7A}, 0, "R5 fifth byte high bits ignored");
        send('{8'h88, 8'h80, 8'h80, 8'h80, 8'h01}, 2, "R5 R6 five bytes");
        send('{8'h81, 8'h82, 8'h83, 8'h84, 8'h85}, 0, "R7 overrun");
        // R10: after completion, further bytes without start are ignored.
        step(1'b0, 1'b1, 8'h03, "R10 idle after overrun");
        step(1'b0, 1'b0, 8'h00, "R10 idle after overrun");
        send('{8'h12}, 0, "R7 error cleared");

        // R9: start in the middle of an immediate, with a byte in the same cycle.
        step(1'b1, 1'b1, 8'hFF, "R9 partial");
        step(1'b0, 1'b1, 8'hFF, "R9 partial");
        step(1'b1, 1'b1, 8'h06, "R9 restart with byte");
        step(1'b0, 1'b0, 8'h00, "R9 restart with byte");
        // R9: start alone, then the byte one cycle later.
        step(1'b1, 1'b1, 8'h9F, "R9 partial 2");
        step(1'b1, 1'b0, 8'h00, "R9 start alone");
        step(1'b0, 1'b1, 8'h11, "R9 start alone");
        // R2: back-to-back immediates, pulse per completion.
        step(1'b1, 1'b1, 8'h01, "R2 back to back");
        step(1'b1, 1'b1, 8'h02, "R2 back to back");
        step(1'b0, 1'b0, 8'h00, "R2 back to back");

        // Random streams covering R2 to R9.
        for (int n = 0; n < 400; n++) begin
            int len = 1 + ($urandom % 5);
            bit ovr = (len == 5) && ($urandom % 4 == 0);
            for (int i = 0; i < len; i++) begin
                logic [7:0] b = 8'($urandom);
                bit s = (i == 0) || ($urandom % 40 == 0);
                b[7] = (i < len - 1) || ovr;
                step(s, 1'b1, b, "R3 R4 R5 random");
                if ($urandom % 3 == 0) step(1'b0, 1'b0, 8'($urandom), "R8 random gap");
            end
            if ($urandom % 4 == 0) step(1'b0, 1'b1, 8'($urandom), "R10 random idle");
            step(1'b0, 1'b0, 8'h00, "R6 random hold");
        end

        finish_run();
    end
endmodule